// File: doc/BRIEF.md
# Throttled Clear-On-Read Interrupt Controller

This block gathers event causes inside a system basis chip and presents them to a host microcontroller. Each cause sets its own bit in a status register. A read strobe returns that register and clears it. An active-low interrupt line, `intn_o`, tells the host that unserviced causes are waiting. Two causes are urgent: a serial clock-count fault and a battery fault. They pull the line low as soon as they are latched. All other causes are recorded when they occur. In Normal mode, however, they can notify the host at most once per watchdog period, so a chattering fault cannot flood the host.

Three wake sources are routed by per-source enable bits: a falling edge on an external wake pin, a CAN bus event and a LIN bus event. Depending on the enable bit and the operating mode, a wake becomes an interrupt cause, a one-cycle reset request, or nothing. After every read, the interrupt line is forced high for a fixed number of cycles. Causes that are still pending then produce a fresh falling edge. A cause that arrives in the same cycle as a read survives the clear.

Top module: `sbc_irq_ctrl`

## Requirements
- R1: Each cause sets a fixed status bit, which stays set until a read or a reset. The bits are: bit 0 serial clock-count fault, bit 1 battery fault, bits 2 to 8 the seven `fault_i` lines (`fault_i[k]` goes to bit 2+k), bit 9 CAN wake, bit 10 LIN wake, bit 11 pin wake and bit 12 watchdog restart. `rd_data_o` always shows the register.
- R2: A clock edge that samples `rd_i` high clears every status bit except those set by causes sampled at that same edge. Those bits remain set.
- R3: Synchronous reset clears the status and enable registers and drives `rst_req_o` low. With nothing pending, `intn_o` is high.
- R4: After each read, `intn_o` is high for exactly HOLD_CYCLES (default 16) consecutive cycles after the read edge, whatever is pending.
- R5: While bit 0 or bit 1 is set and no release window is running, `intn_o` is low in every mode.
- R6: Mode encoding: 0 Standby, 1 Normal, 2 Flash, 3 Sleep. In Normal mode, pending causes in bits 2 to 12 pull `intn_o` low only after a notification is granted. One grant is allowed per period. A read withdraws the grant. A `wd_tick_i` pulse, or leaving reset, opens a new period. In the other modes these causes pull `intn_o` low directly.
- R7: The wake pin passes through a two-flop synchronizer. A falling edge acts only while `wake_global_en_i` is high. With enable bit 0 set, the edge sets bit 11 in modes 0 to 2. With enable bit 0 clear, it requests a reset in Standby and does nothing in the other modes.
- R8: A CAN event (enable bit 1) or a LIN event (enable bit 2) with its enable bit set sets bit 9 or bit 10 in modes 0 to 2, unless the matching active input is high. With its enable bit clear, the event requests a reset in Standby only.
- R9: A watchdog restart sets bit 12 only while enable bit 3 is set. A `wd_overflow_i` pulse clears enable bit 3, and takes priority over a write in the same cycle.
- R10: `en_wr_i` loads `en_wdata_i` into the enable register. `en_q_o` returns it, with bit 0 pin wake, bit 1 CAN, bit 2 LIN and bit 3 watchdog restart.
- R11: A reset request appears on `rst_req_o` as a one-cycle pulse in the cycle after the event is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Operating mode (0 Standby, 1 Normal, 2 Flash, 3 Sleep) |
| can_active_i | input | 1 | CAN transceiver already active |
| lin_active_i | input | 1 | LIN transceiver already active |
| wake_pin_i | input | 1 | Asynchronous wake pin, active falling edge |
| wake_global_en_i | input | 1 | Global enable for the wake pin function |
| spi_fail_i | input | 1 | Serial clock-count fault pulse (urgent) |
| bat_fail_i | input | 1 | Battery fault pulse (urgent) |
| fault_i | input | 7 | Non-urgent fault pulses (temperature, ground shift, bus faults, rails) |
| can_bus_evt_i | input | 1 | CAN bus wake event pulse |
| lin_bus_evt_i | input | 1 | LIN bus wake event pulse |
| wd_restart_i | input | 1 | Watchdog restart event pulse |
| wd_overflow_i | input | 1 | Watchdog overflow pulse |
| wd_tick_i | input | 1 | Start of a new watchdog period |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 4 | Enable register write data |
| en_q_o | output | 4 | Enable register contents |
| rd_i | input | 1 | Status read strobe (read clears) |
| rd_data_o | output | 13 | Status register contents |
| intn_o | output | 1 | Active-low interrupt to host |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
A wrong status bit shows on `rd_data_o` one edge after the cause. A read that loses a colliding cause shows as a zero in the cycle right after the read. A faulty release counter or throttle flag shows on `intn_o` within HOLD_CYCLES+2 cycles of a read or tick. This shows as a release window of the wrong length, or as a second notification inside one period. Routing faults show as a missing or misplaced `rst_req_o` pulse one edge after the bus event, or three edges after the pin falls. The bench follows every output on every cycle against a behavioural model, so each of these faults is reported within a few cycles.

// File: rtl/sbc_irq_pkg.sv
package sbc_irq_pkg;

    typedef enum logic [1:0] {
        MODE_STBY  = 2'd0,
        MODE_NORM  = 2'd1,
        MODE_FLASH = 2'd2,
        MODE_SLEEP = 2'd3
    } op_mode_e;

    localparam int N_FAULT    = 7;
    localparam int N_CAUSE    = 13;
    localparam int N_CRIT     = 2;
    localparam int N_WAKE     = 3;

    localparam int IDX_SPI    = 0;
    localparam int IDX_BAT    = 1;
    localparam int IDX_FAULT0 = 2;
    localparam int IDX_CANWK  = 9;
    localparam int IDX_LINWK  = 10;
    localparam int IDX_PINWK  = 11;
    localparam int IDX_WDR    = 12;

    // enable register layout: bit0 pin, bit1 can, bit2 lin, bit3 watchdog restart
    typedef struct packed {
        logic wdr;
        logic lin;
        logic can;
        logic pin;
    } irq_en_t;

    typedef logic [N_CAUSE-1:0] cause_vec_t;

    function automatic logic mode_awake(op_mode_e m);
        return m != MODE_SLEEP;
    endfunction

endpackage

// File: rtl/sbc_irq_wake_sync.sv
module sbc_irq_wake_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic fall_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= synced;
        end
    end

    assign fall_o = prev_q & ~synced;

    // R7
    fall_single_chk: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/sbc_irq_route.sv
module sbc_irq_route
    import sbc_irq_pkg::*;
#(
    parameter int NW = N_WAKE
) (
    input  logic          clk,
    input  logic          rst,
    input  op_mode_e      mode_i,
    input  logic [NW-1:0] evt_i,
    input  logic [NW-1:0] ie_i,
    input  logic [NW-1:0] busy_i,
    output logic [NW-1:0] irq_set_o,
    output logic          rst_req_o
);

    logic [NW-1:0] req;

    for (genvar g = 0; g < NW; g++) begin : g_src
        assign irq_set_o[g] = evt_i[g] & ie_i[g] & mode_awake(mode_i) & ~busy_i[g];
        assign req[g]       = evt_i[g] & ~ie_i[g] & (mode_i == MODE_STBY);
    end

    always_ff @(posedge clk) begin
        if (rst) rst_req_o <= 1'b0;
        else     rst_req_o <= |req;
    end

    // R7 R8 R11
    rst_req_mode_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> ($past(mode_i) == MODE_STBY));

endmodule

// File: rtl/sbc_irq_throttle.sv
module sbc_irq_throttle
    import sbc_irq_pkg::*;
#(
    parameter int HOLD_CYCLES = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  op_mode_e mode_i,
    input  logic     rd_i,
    input  logic     tick_i,
    input  logic     crit_pend_i,
    input  logic     nc_pend_i,
    output logic     intn_o
);

    localparam int            HW      = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] HOLD_LD = HW'(HOLD_CYCLES);

    logic [HW-1:0] hold_q;
    logic          armed_q;
    logic          grant_q;
    logic          in_normal;
    logic          consume;
    logic          blanked;
    logic          want;

    assign in_normal = (mode_i == MODE_NORM);
    assign consume   = nc_pend_i & armed_q & ~grant_q & in_normal & ~rd_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            armed_q <= 1'b1;
            grant_q <= 1'b0;
        end else begin
            if (rd_i)              hold_q <= HOLD_LD;
            else if (hold_q != '0) hold_q <= hold_q - 1'b1;

            if (tick_i)       armed_q <= 1'b1;
            else if (consume) armed_q <= 1'b0;

            if (rd_i)         grant_q <= 1'b0;
            else if (consume) grant_q <= 1'b1;
        end
    end

    assign blanked = (hold_q != '0);
    assign want    = crit_pend_i | (nc_pend_i & (~in_normal | grant_q));
    assign intn_o  = ~(want & ~blanked);

    // R4
    intn_release_chk: assert property (@(posedge clk) disable iff (rst)
        rd_i |=> intn_o);

    // R6
    one_per_period_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !tick_i) |=> !$rose(grant_q));

endmodule

// File: rtl/sbc_irq_ctrl.sv
module sbc_irq_ctrl
    import sbc_irq_pkg::*;
#(
    parameter int HOLD_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         mode_i,
    input  logic               can_active_i,
    input  logic               lin_active_i,
    input  logic               wake_pin_i,
    input  logic               wake_global_en_i,
    input  logic               spi_fail_i,
    input  logic               bat_fail_i,
    input  logic [N_FAULT-1:0] fault_i,
    input  logic               can_bus_evt_i,
    input  logic               lin_bus_evt_i,
    input  logic               wd_restart_i,
    input  logic               wd_overflow_i,
    input  logic               wd_tick_i,
    input  logic               en_wr_i,
    input  logic [3:0]         en_wdata_i,
    output logic [3:0]         en_q_o,
    input  logic               rd_i,
    output logic [N_CAUSE-1:0] rd_data_o,
    output logic               intn_o,
    output logic               rst_req_o
);

    op_mode_e          mode;
    irq_en_t           en_q;
    cause_vec_t        status_q;
    cause_vec_t        set_vec;
    logic              pin_fall;
    logic [N_WAKE-1:0] wk_evt;
    logic [N_WAKE-1:0] wk_ie;
    logic [N_WAKE-1:0] wk_busy;
    logic [N_WAKE-1:0] wk_set;

    assign mode = op_mode_e'(mode_i);

    sbc_irq_wake_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (wake_pin_i),
        .fall_o (pin_fall)
    );

    // source order: 0 pin, 1 can, 2 lin
    assign wk_evt  = {lin_bus_evt_i, can_bus_evt_i, pin_fall & wake_global_en_i};
    assign wk_ie   = {en_q.lin, en_q.can, en_q.pin};
    assign wk_busy = {lin_active_i, can_active_i, 1'b0};

    sbc_irq_route #(.NW(N_WAKE)) u_route (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode),
        .evt_i     (wk_evt),
        .ie_i      (wk_ie),
        .busy_i    (wk_busy),
        .irq_set_o (wk_set),
        .rst_req_o (rst_req_o)
    );

    always_comb begin
        set_vec                         = '0;
        set_vec[IDX_SPI]                = spi_fail_i;
        set_vec[IDX_BAT]                = bat_fail_i;
        set_vec[IDX_FAULT0 +: N_FAULT]  = fault_i;
        set_vec[IDX_PINWK]              = wk_set[0];
        set_vec[IDX_CANWK]              = wk_set[1];
        set_vec[IDX_LINWK]              = wk_set[2];
        set_vec[IDX_WDR]                = wd_restart_i & en_q.wdr;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (rd_i ? '0 : status_q) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            if (en_wr_i)       en_q     <= irq_en_t'(en_wdata_i);
            if (wd_overflow_i) en_q.wdr <= 1'b0;
        end
    end

    sbc_irq_throttle #(.HOLD_CYCLES(HOLD_CYCLES)) u_thr (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode),
        .rd_i        (rd_i),
        .tick_i      (wd_tick_i),
        .crit_pend_i (|status_q[N_CRIT-1:0]),
        .nc_pend_i   (|status_q[N_CAUSE-1:N_CRIT]),
        .intn_o      (intn_o)
    );

    assign rd_data_o = status_q;
    assign en_q_o    = en_q;

    // R2
    clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_i |=> (status_q == $past(set_vec)));

    // R2
    no_loss_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    // R9
    wdr_selfclear_chk: assert property (@(posedge clk) disable iff (rst)
        wd_overflow_i |=> !en_q_o[3]);

endmodule

// File: tb/sbc_irq_ctrl_tb.sv
module sbc_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic        can_act = 1'b0, lin_act = 1'b0, pin = 1'b1, wge = 1'b1;
    logic        spi = 1'b0, bat = 1'b0;
    logic [6:0]  fault = '0;
    logic        can_evt = 1'b0, lin_evt = 1'b0, wdr = 1'b0, wdo = 1'b0, tick = 1'b0;
    logic        en_wr = 1'b0, rd = 1'b0;
    logic [3:0]  en_wd = '0;
    logic [3:0]  en_q;
    logic [12:0] rdat;
    logic        intn, rreq;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbc_irq_ctrl #(.HOLD_CYCLES(HOLD)) u_dut (
        .clk(clk), .rst(rst), .mode_i(mode), .can_active_i(can_act), .lin_active_i(lin_act),
        .wake_pin_i(pin), .wake_global_en_i(wge), .spi_fail_i(spi), .bat_fail_i(bat),
        .fault_i(fault), .can_bus_evt_i(can_evt), .lin_bus_evt_i(lin_evt),
        .wd_restart_i(wdr), .wd_overflow_i(wdo), .wd_tick_i(tick),
        .en_wr_i(en_wr), .en_wdata_i(en_wd), .en_q_o(en_q),
        .rd_i(rd), .rd_data_o(rdat), .intn_o(intn), .rst_req_o(rreq)
    );

    // behavioural reference model
    logic [12:0] m_st, m_set;
    logic [3:0]  m_en;
    logic        m_armed, m_grant, m_s1, m_s2, m_prev, m_rq, m_fall, m_cons, m_ncp;
    int          m_hold;

    always @(posedge clk) begin
        if (rst) begin
            m_st = '0; m_en = '0; m_armed = 1'b1; m_grant = 1'b0; m_hold = 0;
            m_s1 = 1'b1; m_s2 = 1'b1; m_prev = 1'b1; m_rq = 1'b0;
        end else begin
            m_fall = !m_s2 && m_prev && wge;
            m_set = '0;
            m_rq  = 1'b0;
            m_set[0]   = spi;
            m_set[1]   = bat;
            m_set[8:2] = fault;
            if (m_fall) begin
                if (m_en[0]) begin if (mode != 2'd3) m_set[11] = 1'b1; end
                else if (mode == 2'd0) m_rq = 1'b1;
            end
            if (can_evt) begin
                if (m_en[1]) begin if (mode != 2'd3 && !can_act) m_set[9] = 1'b1; end
                else if (mode == 2'd0) m_rq = 1'b1;
            end
            if (lin_evt) begin
                if (m_en[2]) begin if (mode != 2'd3 && !lin_act) m_set[10] = 1'b1; end
                else if (mode == 2'd0) m_rq = 1'b1;
            end
            if (wdr && m_en[3]) m_set[12] = 1'b1;
            m_ncp  = |m_st[12:2];
            m_cons = m_ncp && m_armed && !m_grant && (mode == 2'd1) && !rd;
            if (rd) m_grant = 1'b0; else if (m_cons) m_grant = 1'b1;
            if (tick) m_armed = 1'b1; else if (m_cons) m_armed = 1'b0;
            m_hold = rd ? HOLD : (m_hold > 0 ? m_hold - 1 : 0);
            m_st = (rd ? 13'd0 : m_st) | m_set;
            if (en_wr) m_en = en_wd;
            if (wdo) m_en[3] = 1'b0;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
        end
    end

    function automatic logic m_intn();
        logic want;
        want = (|m_st[1:0]) || ((|m_st[12:2]) && (mode != 2'd1 || m_grant));
        return !(want && m_hold == 0);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        if (!rst) begin
            chk("R1 R2 status", 32'(rdat), 32'(m_st));
            chk("R4 R5 R6 intn", 32'(intn), 32'(m_intn()));
            chk("R7 R8 R11 rst_req", 32'(rreq), 32'(m_rq));
            chk("R9 R10 enables", 32'(en_q), 32'(m_en));
        end
        spi = 0; bat = 0; fault = '0; can_evt = 0; lin_evt = 0;
        wdr = 0; wdo = 0; tick = 0; en_wr = 0; rd = 0;
    endtask

    task automatic rand_phase(input logic [1:0] md, input int n);
        mode = md;
        wge  = 1'($urandom_range(0, 3) != 0);
        for (int i = 0; i < n; i++) begin
            cyc();
            spi = ($urandom_range(0, 79) == 0);
            bat = ($urandom_range(0, 79) == 0);
            for (int k = 0; k < 7; k++) fault[k] = ($urandom_range(0, 49) == 0);
            can_evt = ($urandom_range(0, 19) == 0);
            lin_evt = ($urandom_range(0, 19) == 0);
            if ($urandom_range(0, 9) == 0) pin = ~pin;
            if ($urandom_range(0, 49) == 0) can_act = ~can_act;
            if ($urandom_range(0, 49) == 0) lin_act = ~lin_act;
            rd   = ($urandom_range(0, 11) == 0);
            tick = (i % 37 == 36);
            wdr  = ($urandom_range(0, 29) == 0);
            wdo  = ($urandom_range(0, 59) == 0);
            if ($urandom_range(0, 39) == 0) begin
                en_wr = 1'b1;
                en_wd = 4'($urandom_range(0, 15));
            end
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int  n;
        logic seen;
        repeat (3) @(negedge clk);
        // R3 reset state
        chk("R3 status", 32'(rdat), 0);
        chk("R3 intn", 32'(intn), 1);
        chk("R3 enables", 32'(en_q), 0);
        chk("R3 rst_req", 32'(rreq), 0);
        rst = 1'b0;

        // R10 enable write and readback
        cyc(); en_wr = 1; en_wd = 4'b0101;
        cyc(); chk("R10 readback", 32'(en_q), 32'h5);

        // R1 battery bit position
        mode = 2'd1; rd = 1;
        cyc(); bat = 1;
        cyc(); chk("R1 battery bit", 32'(rdat), 32'h2);

        // R2 collision of read with a new cause
        rd = 1;
        cyc(); rd = 1; spi = 1;
        cyc(); chk("R2 kept across read", 32'(rdat), 32'h1);
        chk("R4 released after read", 32'(intn), 1);
        n = 0;
        while (intn === 1'b1 && n < 100) begin n++; cyc(); end
        chk("R4 release length", 32'(n), 32'(HOLD));
        chk("R5 urgent asserts", 32'(intn), 0);

        // R6 throttle in Normal mode
        en_wr = 1; en_wd = 4'b0000; rd = 1; tick = 1;
        cyc(); repeat (20) cyc();
        fault = 7'b0000001;
        cyc(); cyc(); chk("R6 first notice", 32'(intn), 0);
        rd = 1;
        cyc(); repeat (20) cyc();
        fault = 7'b0000010;
        cyc(); repeat (3) cyc();
        chk("R6 throttled", 32'(intn), 1);
        chk("R1 recorded while throttled", 32'(rdat[3]), 1);
        tick = 1;
        cyc(); cyc(); chk("R6 new period", 32'(intn), 0);
        rd = 1;
        cyc(); repeat (20) cyc();
        fault = 7'b0000100;
        cyc(); repeat (3) cyc();
        chk("R6 throttled again", 32'(intn), 1);
        mode = 2'd2;
        cyc(); chk("R6 unthrottled in Flash", 32'(intn), 0);

        // R5 urgent cause in Sleep
        rd = 1;
        cyc(); repeat (20) cyc();
        mode = 2'd3; bat = 1;
        cyc(); chk("R5 urgent in Sleep", 32'(intn), 0);

        // R7 wake pin routing
        mode = 2'd0; en_wr = 1; en_wd = 4'b0000; pin = 1;
        repeat (4) cyc();
        pin = 0; seen = 0;
        repeat (4) begin cyc(); if (rreq) seen = 1; end
        chk("R7 reset request in Standby", 32'(seen), 1);
        mode = 2'd1; en_wr = 1; en_wd = 4'b0001; pin = 1;
        repeat (4) cyc();
        rd = 1;
        cyc(); pin = 0;
        repeat (4) cyc();
        chk("R7 pin wake bit", 32'(rdat[11]), 1);
        wge = 0; pin = 1;
        repeat (4) cyc();
        rd = 1;
        cyc(); pin = 0;
        repeat (4) cyc();
        chk("R7 global disable ignores edge", 32'(rdat[11]), 0);
        wge = 1;

        // R8 and R11 bus wake routing
        mode = 2'd0; en_wr = 1; en_wd = 4'b0000;
        cyc(); can_evt = 1;
        cyc(); chk("R8 CAN reset request", 32'(rreq), 1);
        cyc(); chk("R11 single pulse", 32'(rreq), 0);
        mode = 2'd2; lin_evt = 1;
        cyc(); chk("R8 no request outside Standby", 32'(rreq), 0);
        mode = 2'd1; en_wr = 1; en_wd = 4'b0010; rd = 1; can_act = 1;
        cyc(); can_evt = 1;
        cyc(); chk("R8 active transceiver suppresses", 32'(rdat[9]), 0);
        can_act = 0; can_evt = 1;
        cyc(); chk("R8 CAN wake bit", 32'(rdat[9]), 1);

        // R9 watchdog restart enable
        en_wr = 1; en_wd = 4'b1010;
        cyc(); chk("R10 readback two", 32'(en_q), 32'hA);
        wdo = 1; en_wr = 1; en_wd = 4'b1010;
        cyc(); chk("R9 overflow clears", 32'(en_q), 32'h2);
        rd = 1;
        cyc(); wdr = 1;
        cyc(); chk("R9 restart masked", 32'(rdat[12]), 0);
        en_wr = 1; en_wd = 4'b1000;
        cyc(); wdr = 1;
        cyc(); chk("R9 restart recorded", 32'(rdat[12]), 1);

        // random traffic in every mode, model compared each cycle
        rand_phase(2'd1, 400);
        rand_phase(2'd0, 300);
        rand_phase(2'd2, 300);
        rand_phase(2'd3, 200);

        // R3 mid-run reset
        spi = 1;
        cyc(); rst = 1;
        repeat (2) @(negedge clk);
        chk("R3 status after reset", 32'(rdat), 0);
        chk("R3 intn after reset", 32'(intn), 1);
        chk("R3 enables after reset", 32'(en_q), 0);
        chk("R3 rst_req after reset", 32'(rreq), 0);
        rst = 0;
        rand_phase(2'd1, 200);
        cyc();
        finish_run();
    end

endmodule